// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block sits between the protocol engine of a serial EEPROM model and its memory array. When the engine sees a write addressed to the device, it opens a transaction with the full starting byte address. The block keeps the upper address bits as the page number. The lower bits become an in-page offset. Each data byte the engine hands over is stored in a 16-entry buffer at the current offset, and the offset is marked as loaded. The offset then advances and wraps within the page, so that a long burst overwrites its own earlier bytes.

Nothing reaches the array while bytes are being collected. When the engine reports the stop that ends a valid write, the block walks the buffer once in ascending offset order. It drives the RAM write port only for offsets that were loaded, and it raises a busy flag for a write-cycle time set by a parameter in system clocks. The engine refuses the device address while busy is high. An abort from the engine, which covers a write-protect rejection, discards the collected bytes. A fresh transaction start seen before the stop also discards them. In neither case does a write cycle start.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: During a commit, every RAM write uses the page number (`txn_addr` bits above the 4-bit offset) captured at the transaction start. `mem_addr` is {page, offset}.
- R3: The first byte goes to offset `txn_addr[3:0]`, and each later byte goes to the next offset modulo 16. When more than 16 bytes arrive, the last byte given to an offset is the value written.
- R4: No RAM write occurs before a commit. `mem_we` is only ever high while `busy` is high.
- R5: A commit writes each loaded offset exactly once, in ascending offset order starting at offset 0. Offsets that were not loaded keep their old array contents.
- R6: `busy` rises on the cycle after an accepted commit that has at least one loaded byte. It stays high for exactly `WR_CYCLES` cycles, or for 16 cycles if `WR_CYCLES` is below 16.
- R7: While `busy` is high, `txn_start`, `byte_valid`, `commit` and `abort` are ignored. The busy time is not extended, and no further bytes are written.
- R8: An `abort` before the commit discards the loaded bytes. A following `commit` writes nothing and leaves `busy` low.
- R9: A `txn_start` before the commit discards the earlier bytes. Only bytes loaded after the latest start are written.
- R10: A `commit` after a start with no bytes loaded writes nothing and leaves `busy` low.
- R11: `byte_valid` while no transaction is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txn_start | input | 1 | Open a write transaction at `txn_addr` |
| txn_addr | input | ADDR_W | Starting byte address: page number above, in-page offset in the low 4 bits |
| byte_valid | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | DATA_W | Data byte to load |
| abort | input | 1 | Discard the open transaction |
| commit | input | 1 | Stop after a valid write: start the write cycle |
| busy | output | 1 | Write cycle in progress |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM write address |
| mem_wdata | output | DATA_W | RAM write data |

## Verification
The bench goes after wrapping bursts: a start offset near the end of the page, exactly 16 bytes, 20 bytes and 33 bytes. A design that carried the offset into the page number, or that kept the first value instead of the last, would corrupt a neighbouring page or leave stale data. It checks partial pages against a preloaded erased array. A design that copied the whole buffer would overwrite untouched bytes with garbage. It also tries abort, a restart before the stop, an empty commit and stray bytes. A design that got these wrong would launch a write cycle or commit discarded bytes. Finally it fires every input during busy. A design that did not gate them would stretch busy, relaunch, or write a second page.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_OPEN = 1'b1
  } load_state_e;
endpackage

// File: rtl/pgbuf_store.sv
// Page buffer: one data register and one loaded flag per in-page offset.
module pgbuf_store #(
  parameter int PAGE_BYTES = 16,
  parameter int OFF_W      = 4,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [OFF_W-1:0]      wr_off,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [OFF_W-1:0]      rd_off,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PAGE_BYTES-1:0] mask
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_off == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q[g] <= 1'b0;
      else if (clr)    mask_q[g] <= 1'b0;
      else if (hit)    mask_q[g] <= 1'b1;
    end
  end

  assign rd_data = data_q[rd_off];
  assign mask    = mask_q;

  // R3: a stored byte always marks exactly its own offset as loaded
  assert_load_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mask_q[$past(wr_off)]);
endmodule

// File: rtl/pgbuf_timer.sv
// Write-cycle timer: busy for HOLD cycles after load.
module pgbuf_timer #(
  parameter int HOLD  = 16,
  parameter int CNT_W = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(HOLD - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  assert_load_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q);
  assert_fall_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/pgbuf_seq.sv
// Copy sequencer: visits every offset once, ascending, after start.
module pgbuf_seq #(
  parameter int PAGE_BYTES = 16,
  parameter int OFF_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [OFF_W-1:0] idx
);
  logic             active_q, active_d;
  logic [OFF_W-1:0] idx_q, idx_d;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q) begin
      if (idx_q == OFF_W'(PAGE_BYTES - 1)) active_d = 1'b0;
      else                                 idx_d    = idx_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  assign active = active_q;
  assign idx    = idx_q;

  assert_copy_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> (idx_q == '0));
  assert_copy_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> (idx_q == $past(idx_q) + OFF_W'(1)));
endmodule

// File: rtl/eeprom_page_commit.sv
// Page write buffer with deferred commit for a serial EEPROM model.
module eeprom_page_commit
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              abort,
  input  logic              commit,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int HOLD   = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  load_state_e           state_q, state_d;
  logic [OFF_W-1:0]      ptr_q, ptr_d;
  logic [PAGE_W-1:0]     page_q, page_d;
  logic                  tmr_busy, seq_active;
  logic [OFF_W-1:0]      seq_idx;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     rd_data;
  logic                  accept, do_abort, do_start, do_commit, do_byte, launch;

  // Command decode, priority abort > start > commit > byte, all gated by busy
  assign accept    = !tmr_busy;
  assign do_abort  = accept && abort;
  assign do_start  = accept && !abort && txn_start;
  assign do_commit = accept && !abort && !txn_start && commit && (state_q == LD_OPEN);
  assign do_byte   = accept && !abort && !txn_start && !commit && byte_valid
                     && (state_q == LD_OPEN);
  assign launch    = do_commit && (|mask);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    page_d  = page_q;
    if (do_abort) begin
      state_d = LD_IDLE;
    end else if (do_start) begin
      state_d = LD_OPEN;
      ptr_d   = txn_addr[OFF_W-1:0];
      page_d  = txn_addr[ADDR_W-1:OFF_W];
    end else if (do_commit) begin
      state_d = LD_IDLE;
    end else if (do_byte) begin
      ptr_d   = ptr_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= LD_IDLE;
      ptr_q   <= '0;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      page_q  <= page_d;
    end
  end

  pgbuf_store #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (do_abort || do_start),
    .wr_en   (do_byte),
    .wr_off  (ptr_q),
    .wr_data (byte_data),
    .rd_off  (seq_idx),
    .rd_data (rd_data),
    .mask    (mask)
  );

  pgbuf_timer #(.HOLD(HOLD)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (launch),
    .busy  (tmr_busy)
  );

  pgbuf_seq #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (launch),
    .active (seq_active),
    .idx    (seq_idx)
  );

  assign busy      = tmr_busy;
  assign mem_we    = seq_active && mask[seq_idx];
  assign mem_addr  = {page_q, seq_idx};
  assign mem_wdata = rd_data;

  assert_we_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> busy);
  assert_busy_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(commit));
  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:OFF_W]));
  assert_inputs_gated_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> ($stable(page_q) && $stable(mask)));
endmodule

// File: tb/tb_eeprom_page_commit.sv
module tb_eeprom_page_commit;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int WR     = 24;
  localparam int MEM_N  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              txn_start = 1'b0;
  logic [ADDR_W-1:0] txn_addr = '0;
  logic              byte_valid = 1'b0;
  logic [DATA_W-1:0] byte_data = '0;
  logic              abort = 1'b0;
  logic              commit = 1'b0;
  logic              busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  eeprom_page_commit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(16), .WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .abort(abort), .commit(commit),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #10 clk = ~clk;

  logic [DATA_W-1:0] ram [MEM_N];
  logic [DATA_W-1:0] expm [MEM_N];
  int checks = 0;
  int errors = 0;
  int wcount = 0;

  // Array model: erased to 0xFF, written at the RAM port
  initial for (int a = 0; a < MEM_N; a++) begin ram[a] = 8'hFF; expm[a] = 8'hFF; end
  always @(negedge clk) if (rst_n && mem_we) begin
    ram[mem_addr] = mem_wdata;
    wcount++;
  end

  // Vector table: {start address, byte count, first data value}
  localparam logic [26:0] VEC [6] = '{
    {11'h000, 8'd1,  8'h11},
    {11'h123, 8'd5,  8'h40},
    {11'h7F8, 8'd16, 8'hA0},
    {11'h0F0, 8'd20, 8'h00},
    {11'h3AF, 8'd3,  8'h5A},
    {11'h200, 8'd33, 8'hC3}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [ADDR_W-1:0] a);
    txn_start = 1'b1; txn_addr = a;
    @(negedge clk); txn_start = 1'b0;
  endtask
  task automatic push_byte(input logic [DATA_W-1:0] d);
    byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
  endtask
  task automatic pulse_commit();
    commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask
  task automatic pulse_abort();
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  task automatic commit_measure(output int n);
    pulse_commit();
    n = 0;
    while (busy && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic compare_ram(input string req);
    int mism = 0;
    int first = -1;
    for (int a = 0; a < MEM_N; a++)
      if (ram[a] !== expm[a]) begin mism++; if (first < 0) first = a; end
    if (first < 0) first = 0;
    check(mism == 0, req, int'(ram[first]), int'(expm[first]));
  endtask

  initial begin
    int n, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(mem_we == 1'b0, "R1 mem_we after reset", int'(mem_we), 0);

    // Table: R2, R3, R5, R6
    for (int v = 0; v < 6; v++) begin
      logic [10:0] a;
      logic [7:0]  cnt, seed;
      {a, cnt, seed} = VEC[v];
      w0 = wcount;
      pulse_start(a);
      for (int i = 0; i < int'(cnt); i++) push_byte(8'(seed + i));
      for (int i = 0; i < int'(cnt); i++)
        expm[{a[10:4], 4'(a[3:0] + i)}] = 8'(seed + i);
      commit_measure(n);
      check(n == WR, "R6 busy length", n, WR);
      compare_ram("R2/R3 array contents");
      check(wcount - w0 == ((cnt > 16) ? 16 : int'(cnt)), "R5 write count",
            wcount - w0, (cnt > 16) ? 16 : int'(cnt));
    end

    // R8: abort discards
    w0 = wcount;
    pulse_start(11'h400);
    push_byte(8'h01); push_byte(8'h02); push_byte(8'h03);
    pulse_abort();
    pulse_commit();
    check(busy == 1'b0, "R8 busy after aborted commit", int'(busy), 0);
    repeat (20) @(negedge clk);
    check(wcount == w0, "R8 no writes after abort", wcount - w0, 0);
    compare_ram("R8 array unchanged");

    // R9: restart before commit discards earlier bytes
    w0 = wcount;
    pulse_start(11'h500);
    push_byte(8'hEE); push_byte(8'hEF);
    pulse_start(11'h510);
    push_byte(8'h77);
    expm[11'h510] = 8'h77;
    commit_measure(n);
    check(n == WR, "R9 busy length", n, WR);
    check(wcount - w0 == 1, "R9 write count", wcount - w0, 1);
    compare_ram("R9 array contents");

    // R10: empty commit
    w0 = wcount;
    pulse_start(11'h600);
    pulse_commit();
    check(busy == 1'b0, "R10 busy after empty commit", int'(busy), 0);
    repeat (20) @(negedge clk);
    check(wcount == w0, "R10 no writes", wcount - w0, 0);

    // R11: stray bytes with no open transaction
    push_byte(8'h12); push_byte(8'h34);
    pulse_commit();
    check(busy == 1'b0, "R11 busy after stray bytes", int'(busy), 0);
    repeat (20) @(negedge clk);
    check(wcount == w0, "R11 no writes", wcount - w0, 0);
    compare_ram("R11 array unchanged");

    // R7: inputs during busy ignored
    w0 = wcount;
    pulse_start(11'h700);
    push_byte(8'h31);
    expm[11'h700] = 8'h31;
    pulse_commit();
    n = 0;
    n += int'(busy); pulse_abort();
    n += int'(busy); pulse_start(11'h7F0);
    n += int'(busy); push_byte(8'h99);
    n += int'(busy); pulse_commit();
    while (busy && n < 10000) begin n++; @(negedge clk); end
    check(n == WR, "R7 busy length with traffic", n, WR);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R7 no relaunch", int'(busy), 0);
    check(wcount - w0 == 1, "R7 write count", wcount - w0, 1);
    compare_ram("R7 array contents");

    // R4: no write while collecting
    w0 = wcount;
    pulse_start(11'h080);
    push_byte(8'h55); push_byte(8'h66);
    repeat (5) @(negedge clk);
    check(wcount == w0, "R4 no write before commit", wcount - w0, 0);
    check(ram[11'h080] == 8'hFF, "R4 array untouched before commit", int'(ram[11'h080]), 255);
    expm[11'h080] = 8'h55; expm[11'h081] = 8'h66;
    commit_measure(n);
    compare_ram("R4 array after commit");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule